// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels owns the transfer engine when several of them raise a request together. It issues one registered, one-hot grant. The grant stays in place until the engine signals that the granted transfer has finished. After that the arbiter drops the grant for one cycle and then picks again from the requests present at that moment.

Two mode bits select one of four ordering schemes, and the mode may be changed at run time:
- two fixed rankings;
- a round-robin across every channel;
- a hybrid scheme. A four-bit participation mask marks which channels rotate among themselves. The unmarked channels keep a fixed rank and always come first.

A rotation pointer records which channel is currently on top of the rotating order. It advances only when a rotating channel completes a transfer. It returns to channel 0 on reset and whenever the mode changes.

Top module: `dma_prio_arbiter`

## Requirements
- R1: During and after reset, grant is 4'b0000 and grant_valid is 0, and the rotation pointer names channel 0 as the highest rotating priority.
- R2: grant is always zero or one-hot. grant_valid is 1 exactly when grant is nonzero. When no channel requests while the arbiter is idle, grant stays 4'b0000.
- R3: While idle, a nonzero req sampled at a rising edge produces a grant at that same edge, and the grant names only a channel whose req bit was set.
- R4: A grant holds unchanged, whatever req does, until xfer_done is sampled high. At that edge grant returns to 4'b0000 and grant_valid to 0.
- R5: With mode 2'b00, the ranking is channel 0, then 1, then 2, then 3 (lowest set req bit wins).
- R6: With mode 2'b01, the ranking is channel 0, then 2, then 3, then 1.
- R7: With mode 2'b11, channels are searched cyclically starting at the pointer. After channel g completes, the pointer becomes (g+1) mod 4.
- R8: With mode 2'b10, a channel whose rr_mask bit is 0 ranks in the order of R5 and beats every channel whose rr_mask bit is 1. The masked-in channels are searched cyclically from the pointer.
- R9: The pointer moves only on a completed transfer: in mode 2'b11 always, and in mode 2'b10 only if the completed channel has its rr_mask bit set. It never moves in modes 2'b00 and 2'b01.
- R10: In any cycle where mode differs from its value in the previous cycle, the pointer is treated as channel 0 at once, and it stays at 0 from then on until a later completion moves it.
- R11: In mode 2'b11 (and in mode 2'b10 with rr_mask 4'b1111), a channel that keeps requesting sees at most three grants to other channels before it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 4 | Per-channel transfer request, bit i = channel i |
| mode | input | 2 | Ordering scheme: 00 fixed-A, 01 fixed-B, 10 hybrid rotate, 11 full rotate |
| rr_mask | input | 4 | Channels that rotate in hybrid mode |
| xfer_done | input | 1 | Current granted transfer has finished |
| grant | output | 4 | One-hot registered grant |
| grant_valid | output | 1 | A grant is held |

## Verification
The hardest states to reach are hybrid-mode decisions where the pointer sits at a non-zero position. Those states also depend on which earlier completions were from masked-in channels and which were not. To reach them, the bench runs every mask against every request pattern back to back, without resetting in between. The pointer therefore drifts through all positions, and a reference model in the bench follows it.

Pointer clearing on a mode change is provoked directly. The bench advances the rotation, leaves the mode and returns, then presents all four requests.

Fairness is exercised with a long pseudo-random run of request vectors. During this run, a per-channel count of grants made to other channels is kept.

// File: rtl/dma_arb_pkg.sv
// Package: shared mode encoding and ranking helpers for the DMA arbiter.
// Assumes channel counts of at least three for the second fixed ranking.
package dma_arb_pkg;

    typedef enum logic [1:0] {
        MODE_FIX_A  = 2'b00,
        MODE_FIX_B  = 2'b01,
        MODE_HYB_RR = 2'b10,
        MODE_ALL_RR = 2'b11
    } arb_mode_e;

    // Channel placed at a given rank for a fixed ranking variant.
    // Variant 0: natural order. Variant 1: channel 0, then 2..n-1, then 1.
    function automatic int fixed_rank_ch(input int variant, input int rank, input int nch);
        if (variant == 0 || rank == 0) begin
            return rank;
        end
        if (rank == nch - 1) begin
            return 1;
        end
        return rank + 1;
    endfunction

endpackage

// File: rtl/arb_fixed_pick.sv
// Module: combinational fixed-priority picker.
// Returns a one-hot choice of the highest-ranked set bit of cand, or zero.
// VARIANT selects the ranking (see dma_arb_pkg::fixed_rank_ch).
module arb_fixed_pick #(
    parameter int NCH     = 4,
    parameter int VARIANT = 0
) (
    input  logic [NCH-1:0] cand,
    output logic [NCH-1:0] pick
);
    import dma_arb_pkg::*;

    generate
        if (VARIANT == 0) begin : g_natural
            // Lowest index wins.
            always_comb begin
                pick = '0;
                for (int i = NCH - 1; i >= 0; i--) begin
                    if (cand[i]) begin
                        pick = '0;
                        pick[i] = 1'b1;
                    end
                end
            end
        end else begin : g_table
            // Walk the ranking table and take the first candidate.
            always_comb begin
                logic found;
                pick  = '0;
                found = 1'b0;
                for (int r = 0; r < NCH; r++) begin
                    int c;
                    c = fixed_rank_ch(VARIANT, r, NCH);
                    if (!found && cand[c]) begin
                        pick[c] = 1'b1;
                        found   = 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/arb_rot_pick.sv
// Module: combinational rotating picker.
// Searches cand cyclically starting at channel top and returns a one-hot
// choice of the first set bit, or zero. Assumes top < NCH.
module arb_rot_pick #(
    parameter int NCH  = 4,
    parameter int IDXW = 2
) (
    input  logic [NCH-1:0]  cand,
    input  logic [IDXW-1:0] top,
    output logic [NCH-1:0]  pick
);
    // Cyclic first-hit search from the pointer.
    always_comb begin
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            int c;
            c = (int'(top) + k) % NCH;
            if (!found && cand[c]) begin
                pick[c] = 1'b1;
                found   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb_rot_state.sv
// Module: rotation pointer with mode-change clearing.
// Holds the channel that heads the rotating order. A mode change seen this
// cycle forces an effective pointer of 0 at once and clears the register.
// Otherwise a completion of a rotating channel moves the pointer past it.
module arb_rot_state #(
    parameter int NCH  = 4,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            done_fire,
    input  logic            rotate_en,
    input  logic [IDXW-1:0] done_idx,
    output logic [IDXW-1:0] top_eff
);
    logic [1:0]      mode_q;
    logic [IDXW-1:0] top_q;
    logic            mode_chg;

    assign mode_chg = (mode != mode_q);

    // Effective pointer: cleared in the very cycle the mode changes.
    assign top_eff = mode_chg ? '0 : top_q;

    // Track previous mode and advance or clear the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            top_q  <= '0;
        end else begin
            mode_q <= mode;
            if (mode_chg) begin
                top_q <= '0;
            end else if (done_fire && rotate_en) begin
                top_q <= (int'(done_idx) == NCH - 1) ? '0 : done_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
// Module: DMA channel priority arbiter (top).
// Selects one requesting channel according to the mode, registers the grant,
// holds it until xfer_done, then releases for one cycle before re-arbitrating.
// Assumes xfer_done is only meaningful while grant_valid is high.
module dma_prio_arbiter #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [1:0]     mode,
    input  logic [NCH-1:0] rr_mask,
    input  logic           xfer_done,
    output logic [NCH-1:0] grant,
    output logic           grant_valid
);
    import dma_arb_pkg::*;

    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]  pick_a, pick_b, pick_hfix, pick_rot, rot_cand, next_pick;
    logic [IDXW-1:0] top_eff, grant_idx;
    logic            done_fire, rotate_en;

    arb_fixed_pick #(.NCH(NCH), .VARIANT(0)) i_fix_a (
        .cand(req), .pick(pick_a));

    arb_fixed_pick #(.NCH(NCH), .VARIANT(1)) i_fix_b (
        .cand(req), .pick(pick_b));

    arb_fixed_pick #(.NCH(NCH), .VARIANT(0)) i_fix_hyb (
        .cand(req & ~rr_mask), .pick(pick_hfix));

    // Rotating candidates: every request in full mode, masked-in otherwise.
    assign rot_cand = (mode == MODE_ALL_RR) ? req : (req & rr_mask);

    arb_rot_pick #(.NCH(NCH), .IDXW(IDXW)) i_rot (
        .cand(rot_cand), .top(top_eff), .pick(pick_rot));

    // Mode-dependent choice of the next grant.
    always_comb begin
        case (arb_mode_e'(mode))
            MODE_FIX_A:  next_pick = pick_a;
            MODE_FIX_B:  next_pick = pick_b;
            MODE_HYB_RR: next_pick = (|pick_hfix) ? pick_hfix : pick_rot;
            default:     next_pick = pick_rot;
        endcase
    end

    // Encode the held grant as a channel index.
    always_comb begin
        grant_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) begin
                grant_idx = IDXW'(i);
            end
        end
    end

    assign done_fire = grant_valid && xfer_done;
    assign rotate_en = (mode == MODE_ALL_RR) ||
                       ((mode == MODE_HYB_RR) && (|(grant & rr_mask)));

    arb_rot_state #(.NCH(NCH), .IDXW(IDXW)) i_state (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .done_fire(done_fire), .rotate_en(rotate_en),
        .done_idx(grant_idx), .top_eff(top_eff));

    // Grant register: issue when idle, hold until done, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant       <= '0;
            grant_valid <= 1'b0;
        end else if (grant_valid) begin
            if (xfer_done) begin
                grant       <= '0;
                grant_valid <= 1'b0;
            end
        end else if (|next_pick) begin
            grant       <= next_pick;
            grant_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_arb_checker.sv
// Module: property checker for dma_prio_arbiter, attached by bind.
// Assumes the four-channel default configuration.
module dma_arb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] req,
    input logic [1:0] mode,
    input logic       xfer_done,
    input logic [3:0] grant,
    input logic       grant_valid
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_valid_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (grant != 4'b0000));

    p_from_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((grant & $past(req)) == grant));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> $stable(grant));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done) |=> !grant_valid);

    p_fixed_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid) && $past(mode) == 2'b00)
            |-> grant == ($past(req) & (~$past(req) + 4'd1)));

    p_fixed_b_ch0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid) && $past(mode) == 2'b01 && $past(req[0]))
            |-> grant == 4'b0001);

endmodule

bind dma_prio_arbiter dma_arb_checker i_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
    .xfer_done(xfer_done), .grant(grant), .grant_valid(grant_valid));

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [1:0] mode = 2'b00;
    logic [3:0] rr_mask = '0;
    logic       xfer_done = 1'b0;
    logic [3:0] grant;
    logic       grant_valid;

    int tests = 0;
    int fails = 0;
    int top_m = 0;
    logic [1:0] cur_mode = 2'b00;
    bit   track_wait = 0;
    int   waitc [4];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_prio_arbiter i_dma_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .rr_mask(rr_mask),
        .xfer_done(xfer_done), .grant(grant), .grant_valid(grant_valid));

    task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual valid/grant=%b expected=%b", tag, act, expv);
        end
    endtask

    // Reference choice computed from the requirement orderings.
    function automatic logic [3:0] ref_pick(input logic [1:0] m, input logic [3:0] r,
                                            input logic [3:0] msk, input int top);
        int ordb [4] = '{0, 2, 3, 1};
        if (m == 2'b00) begin
            for (int i = 0; i < 4; i++) if (r[i]) return 4'(1 << i);
        end else if (m == 2'b01) begin
            for (int i = 0; i < 4; i++) if (r[ordb[i]]) return 4'(1 << ordb[i]);
        end else begin
            if (m == 2'b10) begin
                for (int i = 0; i < 4; i++) if (r[i] && !msk[i]) return 4'(1 << i);
            end
            for (int k = 0; k < 4; k++) begin
                int c = (top + k) % 4;
                if (r[c] && (m == 2'b11 || msk[c])) return 4'(1 << c);
            end
        end
        return 4'b0000;
    endfunction

    // One arbitration round: present, check grant, complete, check release.
    task automatic do_grant(input logic [1:0] m, input logic [3:0] r,
                            input logic [3:0] msk, input string tag);
        logic [3:0] expg;
        int g;
        @(negedge clk);
        if (m != cur_mode) top_m = 0;
        cur_mode = m;
        mode = m; rr_mask = msk; req = r;
        expg = ref_pick(m, r, msk, top_m);
        @(negedge clk);
        check({grant_valid, grant} == {expg != 0, expg}, tag,
              {grant_valid, grant}, {expg != 0, expg});
        if (expg != 0) begin
            g = 0;
            for (int i = 0; i < 4; i++) if (expg[i]) g = i;
            if (track_wait) begin
                for (int i = 0; i < 4; i++) begin
                    if (i == g || !r[i]) waitc[i] = 0;
                    else begin
                        waitc[i]++;
                        check(waitc[i] <= 3, "R11 starvation bound",
                              5'(waitc[i]), 5'd3);
                    end
                end
            end
            xfer_done = 1'b1; req = '0;
            @(negedge clk);
            xfer_done = 1'b0;
            check({grant_valid, grant} == 5'b0, "R4 release after done",
                  {grant_valid, grant}, 5'b0);
            if (m == 2'b11 || (m == 2'b10 && msk[g])) top_m = (g + 1) % 4;
        end else begin
            req = '0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) waitc[i] = 0;
        repeat (3) @(negedge clk);
        check({grant_valid, grant} == 5'b0, "R1 reset state", {grant_valid, grant}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check({grant_valid, grant} == 5'b0, "R2 idle no request", {grant_valid, grant}, 5'b0);

        // R1: pointer starts at channel 0 in full rotation.
        do_grant(2'b11, 4'b1111, 4'b0000, "R1 pointer at CH0 after reset");

        // R4: grant holds while req changes.
        @(negedge clk);
        mode = 2'b00; cur_mode = 2'b00; top_m = 0; req = 4'b0110;
        @(negedge clk);
        check(grant == 4'b0010, "R3 grant from request", {grant_valid, grant}, 5'b10010);
        req = 4'b0001;
        repeat (3) @(negedge clk);
        check(grant == 4'b0010 && grant_valid, "R4 hold during transfer",
              {grant_valid, grant}, 5'b10010);
        xfer_done = 1'b1; req = '0;
        @(negedge clk);
        xfer_done = 1'b0;
        check(!grant_valid, "R4 release", {grant_valid, grant}, 5'b0);

        // Exhaustive sweeps per mode.
        for (int r = 0; r < 16; r++) do_grant(2'b00, 4'(r), 4'b0000, "R5 fixed-A order");
        for (int r = 0; r < 16; r++) do_grant(2'b01, 4'(r), 4'b0000, "R6 fixed-B order");
        for (int r = 0; r < 16; r++) do_grant(2'b11, 4'(r), 4'b0000, "R7 full rotation");
        for (int r = 15; r >= 0; r--) do_grant(2'b11, 4'(r), 4'b0000, "R7 full rotation desc");
        for (int mk = 0; mk < 16; mk++)
            for (int r = 0; r < 16; r++)
                do_grant(2'b10, 4'(r), 4'(mk), "R8 R9 hybrid rotation");

        // R9: unmasked completion leaves pointer alone.
        do_grant(2'b10, 4'b1000, 4'b1110, "R9 advance to CH0");
        do_grant(2'b10, 4'b0001, 4'b1110, "R9 unmasked CH0 done");
        do_grant(2'b10, 4'b1110, 4'b1110, "R9 pointer unchanged");

        // R10: mode change clears pointer.
        do_grant(2'b11, 4'b0001, 4'b0000, "R10 setup");
        do_grant(2'b11, 4'b1111, 4'b0000, "R10 setup2");
        do_grant(2'b01, 4'b0000, 4'b0000, "R10 leave mode");
        do_grant(2'b11, 4'b1111, 4'b0000, "R10 pointer cleared to CH0");

        // R11: pseudo-random fairness runs.
        track_wait = 1;
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_grant(2'b11, lfsr[3:0] | 4'b1000, 4'b0000, "R11 R7 random full");
        end
        for (int i = 0; i < 4; i++) waitc[i] = 0;
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_grant(2'b10, lfsr[7:4] | 4'b0100, 4'b1111, "R11 R8 random hybrid");
        end
        track_wait = 0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule